// File: doc/BRIEF.md
# CCD Line Pixel Timing Generator

This block produces the horizontal drive timing for one line of an interline CCD readout. A fast system clock is divided into pixel periods of `SUB_PER_PIX` sub-phases. Inside every pixel period the block raises the reset-gate pulse, toggles a pair of complementary horizontal shift clocks and, while the output window is open, issues the reference-level and data-level sampling strobes used by a correlated double sampler. A pixel counter walks the line. A region code tells downstream logic what kind of pixel the data strobe is sampling.

A pulse on `line_start` restarts the line at pixel 0. If no pulse arrives, the line restarts by itself once its length is used up. The rate select picks one of two line lengths: 2760 pixel periods for full-resolution readout and 3004 for the fast-rate and focus-assist readouts. The select is latched only at the start of a line. Starting at pixel `OUT_START`, each line carries the sensor's output pixels in their physical order: dummy bits, then front optical black, then effective pixels, then rear optical black. All outputs are registered and lag the internal counter by one clock.

Top module: `ccd_htg`

## Requirements
- R1: After reset, and until the first `line_start` pulse, the outputs hold `h1`=0, `h2`=1, `rg`=0, `shp`=0, `shd`=0 and `region`=3, whatever the value of `rate_sel`.
- R2: A line restarts by itself after 2760 pixel periods when it was started with `rate_sel`=0, and after 3004 pixel periods when it was started with `rate_sel`=1. One pixel period is `SUB_PER_PIX` clocks (4 by default).
- R3: `h2` is always the inverse of `h1`. `h1` is high for the first half of the sub-phases of each pixel period and low for the second half, so it rises exactly once per pixel period.
- R4: `rg` is high for exactly one clock per pixel period, at sub-phase 0. This is before the reference strobe (sub-phase 1) and before the data strobe (last sub-phase).
- R5: The 2-bit `region` code is 0 for dummy, 1 for front optical black, 2 for effective and 3 for rear optical black or idle. Measured from pixel `OUT_START` (96 by default), a line carries 28 dummy pixels, then 4 front optical-black pixels, then 2088 effective pixels, then 48 rear optical-black pixels. `region` changes only in a clock where `rg` is high.
- R6: `shp` and `shd` each pulse once per pixel period, but only for the 2168 pixels of the output window. Outside the window both stay low and `region` is 3.
- R7: `rate_sel` is sampled only when a line begins, either from a `line_start` pulse or from a restart at the end of a line. A change in the middle of a line does not alter that line's length.
- R8: A `line_start` pulse in the middle of a line restarts the line at once. The first clock after the pulse has been registered shows pixel 0, sub-phase 0 (`rg`=1, `h1`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `SUB_PER_PIX` cycles per pixel period |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle pulse that restarts the line |
| rate_sel | input | 1 | 0 = full-resolution line length, 1 = fast-rate line length |
| h1 | output | 1 | Horizontal shift clock, phase 1 |
| h2 | output | 1 | Horizontal shift clock, phase 2 |
| rg | output | 1 | Reset-gate pulse |
| shp | output | 1 | Reference-level sampling strobe |
| shd | output | 1 | Data-level sampling strobe |
| region | output | 2 | Pixel class code (0 dummy, 1 front OB, 2 effective, 3 rear OB/idle) |

## Verification
The assertions check the local rules on every clock:
- the shift clocks stay complementary;
- `h1` rises only together with the reset gate;
- the reset gate is a single-clock pulse;
- the reference strobe always follows a reset gate;
- the two strobes never overlap;
- the data strobe falls in the low half of `h1`;
- the region code moves only on a pixel boundary.

Whole-line properties can only be shown by the bench's scenarios. These are the exact line length in each rate, the pixel counts per region, the latching of `rate_sel` at a line boundary, and the restart on a mid-line pulse. For these the bench compares every clock of several lines against expected values computed from the pixel index.

// File: rtl/ccd_htg_pkg.sv
package ccd_htg_pkg;

  typedef enum logic [1:0] {
    REG_DUMMY = 2'd0,
    REG_FOB   = 2'd1,
    REG_EFF   = 2'd2,
    REG_TAIL  = 2'd3
  } region_e;

  typedef enum logic {
    RATE_FULL = 1'b0,
    RATE_FAST = 1'b1
  } rate_e;

  typedef struct packed {
    logic    h1;
    logic    rg;
    logic    shp;
    logic    shd;
    region_e region;
  } htg_out_t;

  localparam htg_out_t HTG_IDLE = '{h1: 1'b0, rg: 1'b0, shp: 1'b0, shd: 1'b0, region: REG_TAIL};

endpackage

// File: rtl/ccd_htg_seq.sv
module ccd_htg_seq
  import ccd_htg_pkg::*;
#(
  parameter int SUB_PER_PIX = 4,
  parameter int LEN_FULL    = 2760,
  parameter int LEN_FAST    = 3004,
  parameter int PIX_W       = 12,
  parameter int SUB_W       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  rate_e            rate_in,
  output logic             run,
  output logic [PIX_W-1:0] pix,
  output logic [SUB_W-1:0] sub
);

  localparam logic [PIX_W-1:0] LAST_FULL = PIX_W'(LEN_FULL - 1);
  localparam logic [PIX_W-1:0] LAST_FAST = PIX_W'(LEN_FAST - 1);
  localparam logic [SUB_W-1:0] LAST_SUB  = SUB_W'(SUB_PER_PIX - 1);

  rate_e            rate_q;
  logic [PIX_W-1:0] last_pix;
  logic             at_last_sub;
  logic             at_last_pix;

  assign last_pix    = (rate_q == RATE_FAST) ? LAST_FAST : LAST_FULL;
  assign at_last_sub = (sub == LAST_SUB);
  assign at_last_pix = (pix == last_pix);

  // Sub-phase counter: power-of-two periods wrap naturally, others compare.
  if (SUB_PER_PIX == (1 << SUB_W)) begin : g_sub_pow2
    always_ff @(posedge clk) begin
      if (rst || line_start) sub <= '0;
      else if (run)          sub <= sub + 1'b1;
    end
  end else begin : g_sub_cmp
    always_ff @(posedge clk) begin
      if (rst || line_start) sub <= '0;
      else if (run)          sub <= at_last_sub ? '0 : sub + 1'b1;
    end
  end

  // Pixel counter, run flag and rate latch (rate only taken at a line edge).
  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      pix    <= '0;
      rate_q <= RATE_FULL;
    end else if (line_start) begin
      run    <= 1'b1;
      pix    <= '0;
      rate_q <= rate_in;
    end else if (run && at_last_sub) begin
      if (at_last_pix) begin
        pix    <= '0;
        rate_q <= rate_in;
      end else begin
        pix    <= pix + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ccd_htg_zone.sv
module ccd_htg_zone
  import ccd_htg_pkg::*;
#(
  parameter int OUT_START = 96,
  parameter int N_DUMMY   = 28,
  parameter int N_FOB     = 4,
  parameter int N_EFF     = 2088,
  parameter int N_ROB     = 48,
  parameter int PIX_W     = 12
) (
  input  logic [PIX_W-1:0] pix,
  output region_e          region,
  output logic             in_window
);

  localparam int unsigned B_DUMMY = OUT_START;
  localparam int unsigned B_FOB   = B_DUMMY + N_DUMMY;
  localparam int unsigned B_EFF   = B_FOB + N_FOB;
  localparam int unsigned B_ROB   = B_EFF + N_EFF;
  localparam int unsigned B_END   = B_ROB + N_ROB;

  int unsigned p;
  assign p = 32'(pix);

  always_comb begin
    in_window = (p >= B_DUMMY) && (p < B_END);
    if (!in_window)    region = REG_TAIL;
    else if (p < B_FOB) region = REG_DUMMY;
    else if (p < B_EFF) region = REG_FOB;
    else if (p < B_ROB) region = REG_EFF;
    else                region = REG_TAIL;
  end

endmodule

// File: rtl/ccd_htg_phase.sv
module ccd_htg_phase #(
  parameter int SUB_PER_PIX = 4,
  parameter int SUB_W       = 2
) (
  input  logic [SUB_W-1:0] sub,
  output logic             h1,
  output logic             rg,
  output logic             ref_slot,
  output logic             dat_slot
);

  localparam logic [SUB_W-1:0] HALF     = SUB_W'(SUB_PER_PIX / 2);
  localparam logic [SUB_W-1:0] SLOT_REF = SUB_W'(1);
  localparam logic [SUB_W-1:0] SLOT_DAT = SUB_W'(SUB_PER_PIX - 1);

  assign h1       = (sub < HALF);
  assign rg       = (sub == '0);
  assign ref_slot = (sub == SLOT_REF);
  assign dat_slot = (sub == SLOT_DAT);

endmodule

// File: rtl/ccd_htg.sv
module ccd_htg
  import ccd_htg_pkg::*;
#(
  parameter int SUB_PER_PIX = 4,
  parameter int LEN_FULL    = 2760,
  parameter int LEN_FAST    = 3004,
  parameter int OUT_START   = 96,
  parameter int N_DUMMY     = 28,
  parameter int N_FOB       = 4,
  parameter int N_EFF       = 2088,
  parameter int N_ROB       = 48
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_start,
  input  logic       rate_sel,
  output logic       h1,
  output logic       h2,
  output logic       rg,
  output logic       shp,
  output logic       shd,
  output logic [1:0] region
);

  localparam int LEN_MAX = (LEN_FAST > LEN_FULL) ? LEN_FAST : LEN_FULL;
  localparam int PIX_W   = $clog2(LEN_MAX);
  localparam int SUB_W   = (SUB_PER_PIX > 2) ? $clog2(SUB_PER_PIX) : 1;

  logic             run;
  logic [PIX_W-1:0] pix;
  logic [SUB_W-1:0] sub;
  region_e          zone;
  logic             in_window;
  logic             ph_h1, ph_rg, ph_ref, ph_dat;
  htg_out_t         nxt, out_q;

  ccd_htg_seq #(
    .SUB_PER_PIX(SUB_PER_PIX), .LEN_FULL(LEN_FULL), .LEN_FAST(LEN_FAST),
    .PIX_W(PIX_W), .SUB_W(SUB_W)
  ) u_seq (
    .clk(clk), .rst(rst), .line_start(line_start), .rate_in(rate_e'(rate_sel)),
    .run(run), .pix(pix), .sub(sub)
  );

  ccd_htg_zone #(
    .OUT_START(OUT_START), .N_DUMMY(N_DUMMY), .N_FOB(N_FOB),
    .N_EFF(N_EFF), .N_ROB(N_ROB), .PIX_W(PIX_W)
  ) u_zone (
    .pix(pix), .region(zone), .in_window(in_window)
  );

  ccd_htg_phase #(.SUB_PER_PIX(SUB_PER_PIX), .SUB_W(SUB_W)) u_phase (
    .sub(sub), .h1(ph_h1), .rg(ph_rg), .ref_slot(ph_ref), .dat_slot(ph_dat)
  );

  always_comb begin
    nxt.h1     = ph_h1;
    nxt.rg     = ph_rg;
    nxt.shp    = ph_ref && in_window;
    nxt.shd    = ph_dat && in_window;
    nxt.region = zone;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) out_q <= HTG_IDLE;
    else             out_q <= nxt;
  end

  assign h1     = out_q.h1;
  assign h2     = ~out_q.h1;
  assign rg     = out_q.rg;
  assign shp    = out_q.shp;
  assign shd    = out_q.shd;
  assign region = out_q.region;

endmodule

// File: rtl/ccd_htg_chk.sv
module ccd_htg_chk (
  input logic       clk,
  input logic       rst,
  input logic       h1,
  input logic       h2,
  input logic       rg,
  input logic       shp,
  input logic       shd,
  input logic [1:0] region
);

  p_complement_r3: assert property (@(posedge clk) disable iff (rst) h1 != h2)
    else $error("shift clocks not complementary");

  p_h1_rise_on_rg_r3: assert property (@(posedge clk) disable iff (rst) $rose(h1) |-> rg)
    else $error("h1 rose outside pixel start");

  p_rg_single_r4: assert property (@(posedge clk) disable iff (rst) rg |=> !rg)
    else $error("reset gate wider than one clock");

  p_rg_before_shp_r4: assert property (@(posedge clk) disable iff (rst) shp |-> $past(rg))
    else $error("reference strobe not preceded by reset gate");

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst) !(shp && shd) && !(rg && (shp || shd)))
    else $error("strobes overlap");

  p_shd_low_half_r3: assert property (@(posedge clk) disable iff (rst) shd |-> !h1)
    else $error("data strobe in high half of h1");

  p_region_on_pixel_edge_r5: assert property (@(posedge clk) disable iff (rst) (region != $past(region)) |-> rg)
    else $error("region changed inside a pixel period");

endmodule

bind ccd_htg ccd_htg_chk u_chk (
  .clk(clk), .rst(rst), .h1(h1), .h2(h2), .rg(rg),
  .shp(shp), .shd(shd), .region(region)
);

// File: tb/tb_ccd_htg.sv
`timescale 1ns/1ps
module tb_ccd_htg;

  localparam int SUB  = 4;
  localparam int FULL = 2760;
  localparam int FAST = 3004;
  localparam int OS   = 96;
  localparam int ND = 28, NF = 4, NE = 2088, NR = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_start = 1'b0;
  logic rate_sel = 1'b0;
  logic h1, h2, rg, shp, shd;
  logic [1:0] region;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ccd_htg dut (
    .clk(clk), .rst(rst), .line_start(line_start), .rate_sel(rate_sel),
    .h1(h1), .h2(h2), .rg(rg), .shp(shp), .shd(shd), .region(region)
  );

  task automatic chk(input string tag, input int act, input int exp, input string what);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_region(input int p);
    int r;
    if (p < OS || p >= OS + ND + NF + NE + NR) return 3;
    r = p - OS;
    if (r < ND) return 0;
    if (r < ND + NF) return 1;
    if (r < ND + NF + NE) return 2;
    return 3;
  endfunction

  // Compares every clock of a line against the pixel index.
  task automatic check_cycles(input int len, input int count, input int flip_at,
                              input logic flip_val, input string ltag);
    int cnt[4];
    for (int k = 0; k < 4; k++) cnt[k] = 0;
    for (int n = 0; n < count; n++) begin
      int m, p, s;
      bit win;
      m = n % (len * SUB);
      p = m / SUB;
      s = m % SUB;
      win = (p >= OS) && (p < OS + ND + NF + NE + NR);
      chk("R3", {h1, h2}, (s < SUB / 2) ? 2 : 1, "h1/h2");
      chk("R4", rg, (s == 0) ? 1 : 0, "rg");
      chk("R6", {shp, shd}, {(win && s == 1), (win && s == SUB - 1)}, "shp/shd");
      chk(ltag, region, exp_region(p), "region");
      if (shd && n < len * SUB) cnt[region]++;
      if (n == flip_at) rate_sel = flip_val;
      @(negedge clk);
    end
    if (count >= len * SUB) begin
      chk("R5", cnt[0], ND, "dummy count");
      chk("R5", cnt[1], NF, "front OB count");
      chk("R5", cnt[2], NE, "effective count");
      chk("R5", cnt[3], NR, "rear OB count");
    end
  endtask

  task automatic start_line(input logic rate);
    line_start = 1'b1;
    rate_sel = rate;
    @(negedge clk);
    line_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: idle outputs before any line starts, with rate_sel toggling
    for (int i = 0; i < 10; i++) begin
      rate_sel = i[0];
      @(negedge clk);
      chk("R1", {h1, h2, rg, shp, shd}, 5'b01000, "idle controls");
      chk("R1", region, 3, "idle region");
    end
    // Full-rate line; rate_sel flips mid-line (R7) but the line keeps 2760 pixels
    start_line(1'b0);
    check_cycles(FULL, FULL * SUB, 5000, 1'b1, "R5");
    // Automatic restart picks fast rate (R2 wrap timing, R7 latching)
    check_cycles(FAST, FAST * SUB, 100, 1'b0, "R2/R7");
    // Next line is full rate again; cut short by a mid-line restart
    check_cycles(FULL, 600 * SUB, -1, 1'b0, "R2");
    start_line(1'b1);
    // R8: first clock after restart is pixel 0, sub-phase 0
    chk("R8", {rg, h1}, 2'b11, "restart phase");
    check_cycles(FAST, FAST * SUB + 40, -1, 1'b1, "R8");
    done = 1'b1;
    summary();
    $finish;
  end

endmodule